// File: doc/BRIEF.md
# Dual masked CAN acceptance filter

This block decides whether a received CAN frame should be kept. The 11-bit standard identifier and the RTR bit are joined into one 12-bit compare vector. That vector is tested against two programmable filter/mask pairs. A mask bit of 1 makes the matching filter bit take part in the compare. A mask bit of 0 makes that position a don't-care. A frame is accepted when every selected bit of at least one pair agrees with the vector.

Software programs the filters and masks through a byte-wide register port. Each 12-bit word is split into a high byte and a low nibble. The receive path pulses a strobe together with the identifier and RTR bit of the frame. One clock later the block presents an accept flag and the index of the winning pair. That index drives the acceptance bit of the receive buffer. Pair 0 wins whenever it matches. The filter and mask words have no reset value, so they must be written before they are used.

Top module: `can_accf`

## Requirements
- R1: While rst_ni is low, and after it rises until the first strobe, accept_o is 0 and match_idx_o is 0.
- R2: The compare vector is {id_i[10:0], rtr_i}, with id_i[10] in bit 11 and rtr_i in bit 0. A pair matches when ((vector ^ filter) & mask) == 0.
- R3: A mask bit of 0 excludes that position from the compare. An all-zero mask makes its pair match every frame.
- R4: When pair 0 matches, accept_o becomes 1 and match_idx_o becomes 0, whatever pair 1 does.
- R5: match_idx_o becomes 1 only when pair 0 fails and pair 1 matches. When neither pair matches, accept_o becomes 0 and match_idx_o becomes 0.
- R6: Register address is {pair, kind, half}. Bit 2 selects the pair, bit 1 selects filter (0) or mask (1), and bit 0 selects high (0) or low (1). The high register holds word bits 11:4 in data bits 7:0. Writes take effect at the clock edge, and rdata_o shows the addressed register combinationally.
- R7: The low register holds word bits 3:0 in data bits 7:4. Its data bits 3:0 read as 0, and written values in those bits are ignored. A high-byte write leaves the low nibble unchanged.
- R8: The accept result is registered at the clock edge where frame_valid_i is 1. It holds, whatever id_i and rtr_i do, until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write enable |
| addr_i | input | 3 | Register address {pair, kind, half} |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Read data of the addressed register |
| id_i | input | 11 | Frame identifier |
| rtr_i | input | 1 | Frame RTR bit |
| frame_valid_i | input | 1 | One-cycle strobe: evaluate this frame |
| accept_o | output | 1 | Frame accepted by at least one pair |
| match_idx_o | output | 1 | Index of the accepting pair, 0 preferred |

## Verification
A corrupted filter or mask bit shows up in two places. It is visible on rdata_o as soon as that register is addressed. It also flips the accept flag on the next frame whose vector exercises that bit position. A priority or selection fault appears as a wrong match_idx_o one clock after a strobe, but only on frames where both pairs match or only pair 1 matches. The bench therefore forces all four match combinations directly, and adds random frames and register contents. A result register that fails to hold is caught by changing id_i between strobes and sampling again.

// File: rtl/can_accf_pkg.sv
package can_accf_pkg;
  localparam int unsigned ID_W   = 11;
  localparam int unsigned VEC_W  = ID_W + 1;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned LO_W   = VEC_W - DATA_W;
endpackage

// File: rtl/accf_regs.sv
module accf_regs
  import can_accf_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 2,
  localparam int unsigned PAIR_W   = $clog2(NUM_PAIRS),
  localparam int unsigned ADDR_W   = PAIR_W + 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  output logic [DATA_W-1:0]                 rdata_o,
  output logic [NUM_PAIRS-1:0][VEC_W-1:0]   filt_o,
  output logic [NUM_PAIRS-1:0][VEC_W-1:0]   mask_o
);
  logic [PAIR_W-1:0] sel_pair;
  logic              is_mask, is_low;
  logic [VEC_W-1:0]  word;
  logic [NUM_PAIRS-1:0][VEC_W-1:0] filt_q, mask_q;

  assign sel_pair = addr_i[ADDR_W-1:2];
  assign is_mask  = addr_i[1];
  assign is_low   = addr_i[0];

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic hit_wr;
    assign hit_wr = wr_en_i && (sel_pair == PAIR_W'(p));

    // no reset: contents undefined until software writes them
    always_ff @(posedge clk_i) begin
      if (hit_wr && !is_mask) begin
        if (is_low) filt_q[p][LO_W-1:0]     <= wdata_i[DATA_W-1 -: LO_W];
        else        filt_q[p][VEC_W-1:LO_W] <= wdata_i;
      end
      if (hit_wr && is_mask) begin
        if (is_low) mask_q[p][LO_W-1:0]     <= wdata_i[DATA_W-1 -: LO_W];
        else        mask_q[p][VEC_W-1:LO_W] <= wdata_i;
      end
    end

    // R7
    hi_wr_keeps_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_wr && !is_low) |=> ($stable(filt_q[p][LO_W-1:0]) && $stable(mask_q[p][LO_W-1:0])));
  end

  always_comb begin
    word = is_mask ? mask_q[sel_pair] : filt_q[sel_pair];
    if (is_low) rdata_o = {word[LO_W-1:0], {(DATA_W-LO_W){1'b0}}};
    else        rdata_o = word[VEC_W-1 -: DATA_W];
  end

  assign filt_o = filt_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/accf_cmp.sv
module accf_cmp
  import can_accf_pkg::*;
(
  input  logic [VEC_W-1:0] vec_i,
  input  logic [VEC_W-1:0] filt_i,
  input  logic [VEC_W-1:0] mask_i,
  output logic             hit_o
);
  // mask 1 = compare, 0 = don't care
  assign hit_o = ~|((vec_i ^ filt_i) & mask_i);
endmodule

// File: rtl/accf_sel.sv
module accf_sel #(
  parameter int unsigned NUM_PAIRS = 2,
  localparam int unsigned IDX_W    = $clog2(NUM_PAIRS)
) (
  input  logic [NUM_PAIRS-1:0] hit_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     idx_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = NUM_PAIRS - 1; i >= 0; i--) begin
      if (hit_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |hit_i;
endmodule

// File: rtl/can_accf.sv
module can_accf
  import can_accf_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 2,
  localparam int unsigned PAIR_W   = $clog2(NUM_PAIRS),
  localparam int unsigned ADDR_W   = PAIR_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [ID_W-1:0]   id_i,
  input  logic              rtr_i,
  input  logic              frame_valid_i,
  output logic              accept_o,
  output logic [PAIR_W-1:0] match_idx_o
);
  logic [NUM_PAIRS-1:0][VEC_W-1:0] filt, mask;
  logic [NUM_PAIRS-1:0]            hit;
  logic [VEC_W-1:0]                vec;
  logic                            any_hit;
  logic [PAIR_W-1:0]               win_idx;
  logic                            accept_q;
  logic [PAIR_W-1:0]               idx_q;

  assign vec = {id_i, rtr_i};

  accf_regs #(.NUM_PAIRS(NUM_PAIRS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .filt_o  (filt),
    .mask_o  (mask)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_cmp
    accf_cmp u_cmp (
      .vec_i  (vec),
      .filt_i (filt[p]),
      .mask_i (mask[p]),
      .hit_o  (hit[p])
    );
  end

  accf_sel #(.NUM_PAIRS(NUM_PAIRS)) u_sel (
    .hit_i (hit),
    .any_o (any_hit),
    .idx_o (win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_q <= 1'b0;
      idx_q    <= '0;
    end else if (frame_valid_i) begin
      accept_q <= any_hit;
      idx_q    <= any_hit ? win_idx : '0;
    end
  end

  assign accept_o    = accept_q;
  assign match_idx_o = idx_q;

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_i |=> ($stable(accept_o) && $stable(match_idx_o)));
  // R4
  prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && hit[0]) |=> (accept_o && match_idx_o == '0));
  // R5
  idx1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && !hit[0] && hit[1]) |=> (accept_o && match_idx_o == PAIR_W'(1)));
  // R5
  noacc_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_o |-> (match_idx_o == '0));
endmodule

// File: tb/can_accf_bench.sv
module can_accf_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [10:0] id = '0;
  logic        rtr = 1'b0;
  logic        fv = 1'b0;
  logic        acc;
  logic        idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [11:0] filt_m [2];
  logic [11:0] mask_m [2];
  logic        prev_acc, prev_idx;

  always #5 clk = ~clk;

  can_accf u_can_accf (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .id_i(id), .rtr_i(rtr),
    .frame_valid_i(fv), .accept_o(acc), .match_idx_o(idx)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit pair_hit(int p, logic [11:0] v);
    return ((v ^ filt_m[p]) & mask_m[p]) == 12'h0;
  endfunction

  task automatic wr_reg(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // low written first, junk in data bits 3:0 must be ignored
  task automatic set_word(int p, bit m, logic [11:0] v);
    wr_reg({p[0], m, 1'b1}, {v[3:0], 4'($urandom)});
    wr_reg({p[0], m, 1'b0}, v[11:4]);
    if (m) mask_m[p] = v; else filt_m[p] = v;
  endtask

  task automatic chk_regs();
    for (int p = 0; p < 2; p++) begin
      for (int m = 0; m < 2; m++) begin
        logic [11:0] w;
        w = m ? mask_m[p] : filt_m[p];
        @(negedge clk);
        addr = {p[0], m[0], 1'b0};
        #1 chk("R6 high byte", rdata, w[11:4]);
        addr = {p[0], m[0], 1'b1};
        #1 chk("R7 low nibble", rdata, {w[3:0], 4'h0});
      end
    end
  endtask

  task automatic run_frame(logic [10:0] fid, logic frtr, string tag);
    logic [11:0] v;
    bit h0, h1, ea, ei;
    v  = {fid, frtr};
    h0 = pair_hit(0, v);
    h1 = pair_hit(1, v);
    ea = h0 | h1;
    ei = !h0 && h1;
    @(negedge clk);
    prev_acc = acc; prev_idx = idx;
    id = fid; rtr = frtr; fv = 1'b1;
    #1 chk({"R8 latency acc ", tag}, acc, prev_acc);
    @(negedge clk);
    fv = 1'b0;
    chk({"acc ", tag}, acc, ea);
    chk({"idx ", tag}, idx, ei);
    id = 11'($urandom); rtr = 1'($urandom);
    @(negedge clk);
    @(negedge clk);
    chk({"R8 hold acc ", tag}, acc, ea);
    chk({"R8 hold idx ", tag}, idx, ei);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c4a));
    #1 chk("R1 reset acc", acc, 0);
    chk("R1 reset idx", idx, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset acc", acc, 0);
    chk("R1 after reset idx", idx, 0);

    // directed: pair0 on bits 11:8, pair1 on bits 3:0
    set_word(0, 0, 12'hA00); set_word(0, 1, 12'hF00);
    set_word(1, 0, 12'h005); set_word(1, 1, 12'h00F);
    chk_regs();
    run_frame(11'h502, 1'b1, "R4 both match");       // 0xA05
    run_frame(11'h500, 1'b0, "R4 pair0 only");       // 0xA00
    run_frame(11'h282, 1'b1, "R5 pair1 only");       // 0x505
    run_frame(11'h280, 1'b0, "R5 none");             // 0x500
    // R2: rtr in bit 0 decides pair1
    set_word(1, 1, 12'h001); set_word(1, 0, 12'h001);
    run_frame(11'h280, 1'b1, "R2 rtr bit0 hit");
    run_frame(11'h281, 1'b0, "R2 rtr bit0 miss");
    // R2: id[10] in bit 11
    set_word(0, 1, 12'h800); set_word(0, 0, 12'h800);
    run_frame(11'h400, 1'b0, "R2 id10 msb hit");
    // R3: zero mask accepts all
    set_word(0, 1, 12'h000);
    run_frame(11'h3FF, 1'b0, "R3 zero mask");
    // R7: high write keeps low nibble
    wr_reg(3'b100, 8'h3C);
    filt_m[1][11:4] = 8'h3C;
    chk_regs();

    for (int i = 0; i < 200; i++) begin
      if (i % 20 == 0) begin
        for (int p = 0; p < 2; p++) begin
          set_word(p, 0, 12'($urandom));
          set_word(p, 1, 12'($urandom) & 12'($urandom));
        end
        chk_regs();
      end
      if (i % 3 == 0) begin
        logic [11:0] v;
        int p;
        p = i % 2;
        v = (filt_m[p] & mask_m[p]) | (12'($urandom) & ~mask_m[p]);
        run_frame(v[11:1], v[0], "R2 R4 R5 random hit");
      end else begin
        run_frame(11'($urandom), 1'($urandom), "R2 R5 random");
      end
    end

    // R1: reset clears held result
    set_word(0, 1, 12'h000);
    run_frame(11'h001, 1'b0, "R1 pre-reset");
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R1 mid reset acc", acc, 0);
    chk("R1 mid reset idx", idx, 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule